// File: doc/BRIEF.md
# Segment Access-Mode Address Decoder

This block classifies and translates a 32-bit virtual address for a processor whose address-space layout is programmable. The top half of the space is cut into four 512 MB kernel windows. The bottom half is cut into two 1 GB user windows. Each window has its own 16-bit setting. The setting holds a 3-bit access mode, an error-level bypass flag and a 12-bit physical base.

For each request, the block takes the address and the current privilege level. It reports one of three outcomes: an address error, a hand-off to the TLB, or a direct (unmapped) translation. For a direct translation it also returns the physical address.

The window settings live in three 32-bit registers, written through a simple write port. After reset they hold a conventional fixed layout. Responses are registered and appear one cycle after the request.

Top module: `seg_decode_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_valid`, `rsp_kind` and `rsp_paddr` are all zero.
- R2: A request sampled with `req_valid` high produces `rsp_valid` high on the next cycle. A cycle with `req_valid` low produces `rsp_valid` low on the next cycle.
- R3: Windows are chosen from the address as follows:
  - With address bit 31 clear, bits 31:16 of register 2 are used when bit 30 is clear, and bits 15:0 when bit 30 is set.
  - With bit 31 set, address bits 30:29 choose the window. 00 uses register 1 bits 31:16, 01 uses register 1 bits 15:0, 10 uses register 0 bits 31:16, and 11 uses register 0 bits 15:0.
- R4: Each 16-bit window setting holds mode in bits 2:0, the bypass flag in bit 3 and the physical base in bits 15:4. `rsp_kind` is 0 for unmapped, 1 for TLB and 2 for address error. Listed as (kernel, supervisor, user), the modes behave as follows:
  - mode 0: (0,2,2)
  - mode 1: (1,2,2)
  - mode 2: (1,1,2)
  - mode 3: (1,1,1)
  - mode 4: (0,1,1)
  - mode 5: (0,0,2)
  - mode 7: (0,0,0)
- R5: Mode 6 is reserved. It gives an address error for supervisor and user, and is unmapped for kernel and error level.
- R6: `req_priv` encodes 0 as kernel, 1 as supervisor, 2 as user and 3 as error level. At error level, a window whose bypass flag is set is unmapped. Otherwise error level behaves exactly like kernel.
- R7: For an unmapped outcome, the physical address is (base << 20) with the window-size bits cleared, ORed with the address masked to the window size. The window size is 29 bits for kernel windows and 30 bits for user windows. For any other outcome `rsp_paddr` is zero.
- R8: A write with `cfg_we` high replaces register `cfg_idx`, where index 0, 1 or 2 is valid. The write is used by requests from the next cycle onward; a request in the same cycle sees the old value. Index 3 writes change nothing.
- R9: Kernel and error-level requests never produce an address error.
- R10: After reset the registers read as follows:
  - register 0 = 0x0002_0001
  - register 1 = 0
  - register 2 = 0x000B_400B
  
  With these values, kernel windows at 0x8/0xA are direct with base 0, and the 0xC window is open to kernel and supervisor through the TLB. The 0xE window is kernel-only through the TLB. The user region is TLB-mapped at all levels, with error-level bypass giving an identity translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Register index for the write |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Virtual address |
| req_priv | input | 2 | Privilege level |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_kind | output | 2 | Outcome: unmapped, TLB or address error |
| rsp_paddr | output | 32 | Physical address for unmapped outcomes, else zero |

## Verification
Directed requests first probe the reset layout at each window, at each privilege level. These show whether window routing and the default mode table agree. A write to the unused index is followed by the same probes, which show whether it leaked into any register. Settings with mode 6, a nonzero base and the bypass flag separate the reserved-mode rule, the base/mask merge and the error-level bypass. Long random runs mix writes colliding with requests, and addresses clustered at window boundaries, which exposes stale-config ordering and off-by-one window selection.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int VA_W       = 32;
    localparam int HALF_W     = 16;
    localparam int MODE_W     = 3;
    localparam int BASE_W     = 12;
    localparam int BASE_SHIFT = VA_W - BASE_W;
    localparam int NUM_REGS   = 3;
    localparam int IDX_W      = 2;
    localparam int KWIN_BITS  = 29;
    localparam int UWIN_BITS  = 30;

    typedef enum logic [1:0] {
        PRIV_KERN = 2'd0,
        PRIV_SUPV = 2'd1,
        PRIV_USER = 2'd2,
        PRIV_ERRL = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        OUT_UNMAP   = 2'd0,
        OUT_TLB     = 2'd1,
        OUT_ADDRERR = 2'd2
    } outcome_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              bypass;
        logic [MODE_W-1:0] mode;
    } wincfg_t;

    // Outcome of an access mode for kernel, supervisor or user level.
    function automatic outcome_e mode_outcome(input logic [MODE_W-1:0] mode,
                                              input priv_e lvl);
        outcome_e r;
        unique case (mode)
            3'd0: r = (lvl == PRIV_KERN) ? OUT_UNMAP : OUT_ADDRERR;
            3'd1: r = (lvl == PRIV_KERN) ? OUT_TLB   : OUT_ADDRERR;
            3'd2: r = (lvl == PRIV_USER) ? OUT_ADDRERR : OUT_TLB;
            3'd3: r = OUT_TLB;
            3'd4: r = (lvl == PRIV_KERN) ? OUT_UNMAP : OUT_TLB;
            3'd5: r = (lvl == PRIV_USER) ? OUT_ADDRERR : OUT_UNMAP;
            3'd6: r = (lvl == PRIV_KERN) ? OUT_UNMAP : OUT_ADDRERR;
            default: r = OUT_UNMAP;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/seg_cfg_bank.sv
module seg_cfg_bank
    import seg_pkg::*;
#(
    parameter int NUM = NUM_REGS,
    parameter int W   = VA_W,
    parameter logic [NUM*W-1:0] RESET_VAL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   idx,
    input  logic [W-1:0]       wdata,
    output logic [NUM*W-1:0]   cfg_flat
);
    logic [W-1:0] cfg_d [NUM];
    logic [W-1:0] cfg_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        always_comb begin
            cfg_d[g] = cfg_q[g];
            if (we && (int'(idx) == g)) cfg_d[g] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg_q[g] <= RESET_VAL[g*W +: W];
            else        cfg_q[g] <= cfg_d[g];
        end

        assign cfg_flat[g*W +: W] = cfg_q[g];
    end

    assert_ignored_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (int'(idx) >= NUM)) |=> $stable(cfg_flat));
endmodule

// File: rtl/seg_route.sv
module seg_route
    import seg_pkg::*;
(
    input  logic [2:0]             addr_top,
    input  logic [NUM_REGS*VA_W-1:0] cfg_flat,
    output wincfg_t                sel,
    output logic [VA_W-1:0]        size_mask
);
    localparam logic [VA_W-1:0] KMASK = (VA_W'(1) << KWIN_BITS) - 1;
    localparam logic [VA_W-1:0] UMASK = (VA_W'(1) << UWIN_BITS) - 1;

    logic [VA_W-1:0] r0, r1, r2;
    assign r0 = cfg_flat[0*VA_W +: VA_W];
    assign r1 = cfg_flat[1*VA_W +: VA_W];
    assign r2 = cfg_flat[2*VA_W +: VA_W];

    always_comb begin
        if (!addr_top[2]) begin
            sel       = addr_top[1] ? r2[HALF_W-1:0] : r2[VA_W-1:HALF_W];
            size_mask = UMASK;
        end else begin
            unique case (addr_top[1:0])
                2'b00:   sel = r1[VA_W-1:HALF_W];
                2'b01:   sel = r1[HALF_W-1:0];
                2'b10:   sel = r0[VA_W-1:HALF_W];
                default: sel = r0[HALF_W-1:0];
            endcase
            size_mask = KMASK;
        end
    end
endmodule

// File: rtl/seg_policy.sv
module seg_policy
    import seg_pkg::*;
(
    input  wincfg_t         win,
    input  priv_e           priv,
    input  logic [VA_W-1:0] addr,
    input  logic [VA_W-1:0] size_mask,
    output outcome_e        kind,
    output logic [VA_W-1:0] paddr
);
    logic [VA_W-1:0] base_full;
    priv_e           lvl;

    assign base_full = {win.base, {BASE_SHIFT{1'b0}}};
    assign lvl       = (priv == PRIV_ERRL) ? PRIV_KERN : priv;

    always_comb begin
        if (priv == PRIV_ERRL && win.bypass) kind = OUT_UNMAP;
        else                                 kind = mode_outcome(win.mode, lvl);
        paddr = (kind == OUT_UNMAP) ? ((base_full & ~size_mask) | (addr & size_mask))
                                    : '0;
    end
endmodule

// File: rtl/seg_decode_unit.sv
module seg_decode_unit
    import seg_pkg::*;
#(
    parameter logic [NUM_REGS*VA_W-1:0] CFG_RESET =
        {32'h000B_400B, 32'h0000_0000, 32'h0002_0001}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [VA_W-1:0]  cfg_wdata,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_addr,
    input  logic [1:0]       req_priv,
    output logic             rsp_valid,
    output logic [1:0]       rsp_kind,
    output logic [VA_W-1:0]  rsp_paddr
);
    typedef struct packed {
        logic            valid;
        outcome_e        kind;
        logic [VA_W-1:0] paddr;
    } rsp_t;

    logic [NUM_REGS*VA_W-1:0] cfg_flat;
    wincfg_t                  win;
    logic [VA_W-1:0]          size_mask;
    outcome_e                 kind_c;
    logic [VA_W-1:0]          paddr_c;
    rsp_t                     rsp_d, rsp_q;

    seg_cfg_bank #(.NUM(NUM_REGS), .W(VA_W), .RESET_VAL(CFG_RESET)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
        .wdata(cfg_wdata), .cfg_flat(cfg_flat)
    );

    seg_route u_route (
        .addr_top(req_addr[VA_W-1:VA_W-3]), .cfg_flat(cfg_flat),
        .sel(win), .size_mask(size_mask)
    );

    seg_policy u_policy (
        .win(win), .priv(priv_e'(req_priv)), .addr(req_addr),
        .size_mask(size_mask), .kind(kind_c), .paddr(paddr_c)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.kind  = kind_c;
            rsp_d.paddr = paddr_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_kind  = rsp_q.kind;
    assign rsp_paddr = rsp_q.paddr;

    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_kernel_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_priv == PRIV_KERN || req_priv == PRIV_ERRL))
        |=> (rsp_kind != OUT_ADDRERR));
    assert_pa_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != OUT_UNMAP) |-> (rsp_paddr == '0));
    assert_pa_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == OUT_UNMAP)
        |-> (rsp_paddr[KWIN_BITS-1:0] == $past(req_addr[KWIN_BITS-1:0])));
endmodule

// File: tb/seg_decode_unit_test.sv
module seg_decode_unit_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_idx = 0;
    logic [31:0] cfg_wdata = 0;
    logic        req_valid = 0;
    logic [31:0] req_addr = 0;
    logic [1:0]  req_priv = 0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mcfg [3];
    logic        pend_v = 0;
    logic [1:0]  pend_k = 0;
    logic [31:0] pend_pa = 0;
    string       pend_tag = "R2";

    always #2 clk = ~clk;

    seg_decode_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_paddr(rsp_paddr)
    );

    // Mode table per R4/R5: lvl 0 kernel, 1 supervisor, 2 user.
    function automatic logic [1:0] tbl(input logic [2:0] m, input int lvl);
        case (m)
            3'd0: return (lvl == 0) ? 2'd0 : 2'd2;
            3'd1: return (lvl == 0) ? 2'd1 : 2'd2;
            3'd2: return (lvl == 2) ? 2'd2 : 2'd1;
            3'd3: return 2'd1;
            3'd4: return (lvl == 0) ? 2'd0 : 2'd1;
            3'd5: return (lvl == 2) ? 2'd2 : 2'd0;
            3'd6: return (lvl == 0) ? 2'd0 : 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [33:0] model(input logic [31:0] a, input logic [1:0] p);
        logic [15:0] w;
        logic [31:0] msk;
        logic [1:0]  k;
        logic [31:0] pa;
        if (!a[31]) begin
            w   = a[30] ? mcfg[2][15:0] : mcfg[2][31:16];
            msk = 32'h3FFF_FFFF;
        end else begin
            case (a[30:29])
                2'b00: w = mcfg[1][31:16];
                2'b01: w = mcfg[1][15:0];
                2'b10: w = mcfg[0][31:16];
                default: w = mcfg[0][15:0];
            endcase
            msk = 32'h1FFF_FFFF;
        end
        if (p == 2'd3 && w[3]) k = 2'd0;
        else k = tbl(w[2:0], (p == 2'd3) ? 0 : int'(p));
        pa = (k == 2'd0) ? (({w[15:4], 20'h0} & ~msk) | (a & msk)) : 32'h0;
        return {k, pa};
    endfunction

    task automatic step(input logic we, input logic [1:0] idx, input logic [31:0] wd,
                        input logic v, input logic [31:0] a, input logic [1:0] p,
                        input string tag);
        @(negedge clk);
        checks++;
        if (pend_v) begin
            if (!(rsp_valid === 1'b1 && rsp_kind === pend_k && rsp_paddr === pend_pa)) begin
                errors++;
                $display("FAIL %s: got v=%0b k=%0d pa=%h expected v=1 k=%0d pa=%h",
                         pend_tag, rsp_valid, rsp_kind, rsp_paddr, pend_k, pend_pa);
            end
        end else if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: got v=%0b expected v=0", rsp_valid);
        end
        pend_v   = v;
        pend_tag = tag;
        if (v) {pend_k, pend_pa} = model(a, p);
        if (we && idx < 2'd3) mcfg[idx] = wd;
        cfg_we = we; cfg_idx = idx; cfg_wdata = wd;
        req_valid = v; req_addr = a; req_priv = p;
    endtask

    task automatic probe_all(input string tag);
        for (int w = 0; w < 6; w++) begin
            for (int p = 0; p < 4; p++) begin
                logic [31:0] a;
                a = (w < 2) ? {1'b0, w[0], 30'h0123_4567}
                            : {1'b1, 2'(w - 2), 29'h0A5A_5A5A};
                step(0, 0, 0, 1, a, 2'(p), tag);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        mcfg[0] = 32'h0002_0001;
        mcfg[1] = 32'h0000_0000;
        mcfg[2] = 32'h000B_400B;
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 0 || rsp_kind !== 0 || rsp_paddr !== 0) begin
            errors++;
            $display("FAIL R1: got v=%0b k=%0d pa=%h expected 0 0 0",
                     rsp_valid, rsp_kind, rsp_paddr);
        end
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 0 || rsp_kind !== 0 || rsp_paddr !== 0) begin
            errors++;
            $display("FAIL R1: got v=%0b k=%0d pa=%h expected 0 0 0 after release",
                     rsp_valid, rsp_kind, rsp_paddr);
        end

        // Reset layout across all windows and levels (R10, R3, R4)
        probe_all("R10 R3 R4");
        // Hard-coded: kernel direct window, error-level identity in user region
        step(0, 0, 0, 1, 32'h9234_5678, 2'd0, "R10 R7 kseg direct");
        step(0, 0, 0, 1, 32'h4000_1234, 2'd3, "R10 R6 bypass identity");
        step(0, 0, 0, 0, 0, 0, "R2 idle");
        checks++;
        if (rsp_kind !== 2'd0 || rsp_paddr !== 32'h4000_1234) begin
            errors++;
            $display("FAIL R6: got k=%0d pa=%h expected k=0 pa=40001234", rsp_kind, rsp_paddr);
        end

        // Write to the unused index must not leak (R8)
        step(1, 2'd3, 32'hFFFF_FFFF, 0, 0, 0, "R8");
        probe_all("R8 ignored index");

        // Reserved mode, base merge, bypass off (R5, R7, R6)
        step(1, 2'd1, 32'h7FF6_ABC6, 0, 0, 0, "R5");
        probe_all("R5 R7 mode6");
        step(1, 2'd2, 32'h1230_ABC0, 1, 32'h2345_6789, 2'd3, "R8 same-cycle old cfg");
        probe_all("R6 R7 bypass clear");
        // Write visible on the very next request (R8)
        step(1, 2'd0, 32'h0057_FFF4, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 32'hC000_0010, 2'd2, "R8 next-cycle new cfg");
        step(0, 0, 0, 1, 32'hFFFF_FFFF, 2'd1, "R4 R7 top window");

        // Constrained random with boundary-clustered addresses
        for (int i = 0; i < 3000; i++) begin
            logic        we;
            logic [31:0] a;
            we = ($urandom % 5) == 0;
            case ($urandom % 4)
                0: a = {3'($urandom), 29'h0};
                1: a = {3'($urandom), 29'h1FFF_FFFF};
                default: a = $urandom;
            endcase
            step(we, 2'($urandom), $urandom, 1'($urandom % 4 != 0), a,
                 2'($urandom), "R3 R4 R5 R6 R7 R8 R9 random");
        end
        step(0, 0, 0, 0, 0, 0, "R2 drain");
        step(0, 0, 0, 0, 0, 0, "R2 drain");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule